// File: doc/BRIEF.md
# Compressed DRAM Test-Mode Logic

This block sits on the array side of a DRAM whose cells are grouped internally as bytes and reached from outside through a 4-bit data bus. It has two modes. In normal mode it acts as a plain nibble memory. In compressed test mode, one write fills a whole internal byte from a single data pin. A read in test mode reports only whether all bits of the addressed byte agree. A tester can therefore write a pattern and check it in half the accesses.

Strobe timing and analog sensing have already been decoded before this block. Each clock cycle carries one cycle-type code, an address and a data nibble. A cycle where write-enable and column strobe are both low before row strobe falls is presented as an entry code. It switches test mode on. Any of the three refresh kinds switches it off. Read data is registered, and it is driven only after a read cycle that has output enable asserted.

Top module: `tm_dram_compress`

## Requirements
- R1: After reset, `test_active` is 0 and `dq_oe` is 0, so the block starts in normal mode.
- R2: Cycle codes are 0 idle, 1 read, 2 write, 3 test entry, 4 CAS-before-RAS refresh, 5 RAS-only refresh, 6 hidden refresh, and 7 reserved, which acts as idle. An entry cycle sets `test_active` in the following cycle. It stays set through idle, read, write, reserved and repeated entry cycles.
- R3: Each of the three refresh codes (4, 5, 6) clears `test_active` in the following cycle. In normal mode a refresh leaves it at 0.
- R4: In normal mode, a write stores `din` in the nibble chosen by `addr[0]` (0 selects byte bits 3:0, 1 selects bits 7:4) of the byte at `addr[ADDR_W-1:1]`. The other nibble keeps its value.
- R5: In normal mode, a read with `oe` set returns the stored nibble on `dq_out`, with `dq_oe` high, in the cycle after the read.
- R6: In test mode, a write sets all 8 bits of the addressed byte to `din[0]`. `din[3:1]` and `addr[0]` have no effect.
- R7: In test mode, a read with `oe` returns `dq_out[3]` = 1 when all 8 bits of the byte are equal and 0 otherwise. `dq_out[2:0]` is always 3'b111.
- R8: `dq_oe` is 1 only in the cycle after a read with `oe` set. Whenever `dq_oe` is 0, `dq_out` is 0.
- R9: Idle, entry, refresh and reserved cycles do not change stored data.
- R10: In test mode, the read result does not depend on `addr[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_kind | input | 3 | Decoded cycle type, encoded as listed in R2 |
| addr | input | ADDR_W (5) | Byte row in the upper bits, nibble select in bit 0 |
| din | input | DQ_W (4) | Write data |
| oe | input | 1 | Output enable for read cycles |
| dq_out | output | DQ_W (4) | Registered read data or compare result |
| dq_oe | output | 1 | Output drive enable; low means the bus is high impedance |
| test_active | output | 1 | Compressed test mode is on |

## Verification
The hardest outcome to reach is a failing compare (result 0). A test-mode write can only produce uniform bytes, so a mismatched byte can never be created while test mode is on. The stimulus therefore writes both nibbles of a byte in normal mode, for all 256 byte values. It then enters test mode, reads the byte with both values of `addr[0]`, and leaves test mode again. The exit uses the three refresh kinds in turn.

// File: rtl/tm_pkg.sv
package tm_pkg;
   typedef enum logic [2:0] {
      CYC_IDLE    = 3'd0,
      CYC_READ    = 3'd1,
      CYC_WRITE   = 3'd2,
      CYC_ENTER   = 3'd3,
      CYC_REF_CBR = 3'd4,
      CYC_REF_ROR = 3'd5,
      CYC_REF_HID = 3'd6,
      CYC_RSVD    = 3'd7
   } cyc_e;

   function automatic logic is_exit(cyc_e k);
      return (k == CYC_REF_CBR) || (k == CYC_REF_ROR) || (k == CYC_REF_HID);
   endfunction
endpackage

// File: rtl/tm_mode_ctl.sv
module tm_mode_ctl
   import tm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  cyc_e kind,
   output logic test_active
);
   always_ff @(posedge clk) begin
      if (!rst_n)                test_active <= 1'b0;
      else if (kind == CYC_ENTER) test_active <= 1'b1;
      else if (is_exit(kind))     test_active <= 1'b0;
   end

   a_r2_enter_sets: assert property (@(posedge clk) disable iff (!rst_n)
      kind == CYC_ENTER |=> test_active);
   a_r3_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      is_exit(kind) |=> !test_active);
   a_r2_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CYC_IDLE || kind == CYC_READ || kind == CYC_WRITE || kind == CYC_RSVD)
      |=> test_active == $past(test_active));
endmodule

// File: rtl/tm_group_array.sv
module tm_group_array #(
   parameter int ROW_W = 4,
   parameter int DQ_W  = 4,
   parameter int LANES = 2,
   localparam int DEPTH   = 1 << ROW_W,
   localparam int GROUP_W = DQ_W * LANES
) (
   input  logic               clk,
   input  logic [LANES-1:0]   lane_we,
   input  logic [ROW_W-1:0]   row,
   input  logic [GROUP_W-1:0] wdata,
   output logic [GROUP_W-1:0] rdata
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DQ_W-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (lane_we[l]) cells[row] <= wdata[l*DQ_W +: DQ_W];
      end
      assign rdata[l*DQ_W +: DQ_W] = cells[row];
   end
endmodule

// File: rtl/tm_data_path.sv
module tm_data_path #(
   parameter int DQ_W  = 4,
   parameter int LANES = 2,
   localparam int SEL_W   = $clog2(LANES),
   localparam int GROUP_W = DQ_W * LANES
) (
   input  logic               test_active,
   input  logic               do_write,
   input  logic [SEL_W-1:0]   sel,
   input  logic [DQ_W-1:0]    din,
   input  logic [GROUP_W-1:0] grp,
   output logic [LANES-1:0]   lane_we,
   output logic [GROUP_W-1:0] wdata,
   output logic [DQ_W-1:0]    rnib
);
   logic [DQ_W-1:0] norm_nib;
   logic            all_same;

   for (genvar l = 0; l < LANES; l++) begin : g_wr
      assign wdata[l*DQ_W +: DQ_W] = test_active ? {DQ_W{din[0]}} : din;
      assign lane_we[l] = do_write & (test_active | (sel == SEL_W'(l)));
   end

   always_comb begin
      norm_nib = '0;
      for (int l = 0; l < LANES; l++) begin
         if (sel == SEL_W'(l)) norm_nib = grp[l*DQ_W +: DQ_W];
      end
   end

   assign all_same = (&grp) | ~(|grp);
   assign rnib = test_active ? {all_same, {(DQ_W-1){1'b1}}} : norm_nib;
endmodule

// File: rtl/tm_dram_compress.sv
module tm_dram_compress
   import tm_pkg::*;
#(
   parameter int DQ_W    = 4,
   parameter int GROUP_W = 8,
   parameter int ROW_W   = 4,
   localparam int LANES  = GROUP_W / DQ_W,
   localparam int SEL_W  = $clog2(LANES),
   localparam int ADDR_W = ROW_W + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cyc_kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   din,
   input  logic              oe,
   output logic [DQ_W-1:0]   dq_out,
   output logic              dq_oe,
   output logic              test_active
);
   if (GROUP_W % DQ_W != 0 || LANES < 2 || (1 << SEL_W) != LANES || DQ_W < 2) begin : g_bad_cfg
      $error("tm_dram_compress: GROUP_W must be a power-of-two multiple (>=2) of DQ_W, DQ_W>=2");
   end

   cyc_e               kind;
   logic [GROUP_W-1:0] grp, wdata;
   logic [LANES-1:0]   lane_we;
   logic [DQ_W-1:0]    rnib;
   logic               rd_fire;

   assign kind    = cyc_e'(cyc_kind);
   assign rd_fire = (kind == CYC_READ) && oe;

   tm_mode_ctl u_mode (
      .clk(clk), .rst_n(rst_n), .kind(kind), .test_active(test_active)
   );

   tm_data_path #(.DQ_W(DQ_W), .LANES(LANES)) u_path (
      .test_active(test_active), .do_write(kind == CYC_WRITE),
      .sel(addr[SEL_W-1:0]), .din(din), .grp(grp),
      .lane_we(lane_we), .wdata(wdata), .rnib(rnib)
   );

   tm_group_array #(.ROW_W(ROW_W), .DQ_W(DQ_W), .LANES(LANES)) u_arr (
      .clk(clk), .lane_we(lane_we), .row(addr[ADDR_W-1:SEL_W]),
      .wdata(wdata), .rdata(grp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dq_oe  <= 1'b0;
         dq_out <= '0;
      end else if (rd_fire) begin
         dq_oe  <= 1'b1;
         dq_out <= rnib;
      end else begin
         dq_oe  <= 1'b0;
         dq_out <= '0;
      end
   end

   a_r8_oe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $past(kind == CYC_READ && oe));
   a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> dq_out == '0);
   a_r7_pad_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(test_active)) |-> (&dq_out[DQ_W-2:0]));
endmodule

// File: tb/tb_tm_dram_compress.sv
module tb_tm_dram_compress;
   logic       clk = 0;
   logic       rst_n = 0;
   logic [2:0] cyc_kind = 0;
   logic [4:0] addr = 0;
   logic [3:0] din = 0;
   logic       oe = 0;
   logic [3:0] dq_out;
   logic       dq_oe, test_active;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [7:0] model [16];

   always #2.5 clk = ~clk;

   tm_dram_compress dut (
      .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .addr(addr), .din(din),
      .oe(oe), .dq_out(dq_out), .dq_oe(dq_oe), .test_active(test_active)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(logic [2:0] k, logic [4:0] a, logic [3:0] d, logic o);
      @(negedge clk);
      cyc_kind = k; addr = a; din = d; oe = o;
      @(negedge clk);
      cyc_kind = 0; oe = 0;
   endtask

   task automatic nread(logic [4:0] a, string req);
      logic [3:0] e;
      e = a[0] ? model[a[4:1]][7:4] : model[a[4:1]][3:0];
      cyc(3'd1, a, 4'h0, 1'b1);
      chk(req, {3'b0, dq_oe, dq_out}, {3'b0, 1'b1, e});
   endtask

   task automatic tread(logic [4:0] a, string req);
      logic eq;
      eq = (model[a[4:1]] == 8'h00) || (model[a[4:1]] == 8'hFF);
      cyc(3'd1, a, 4'h0, 1'b1);
      chk(req, {3'b0, dq_oe, dq_out}, {3'b0, 1'b1, eq, 3'b111});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 test_active", {7'b0, test_active}, 8'h0);
      chk("R1 dq_oe", {7'b0, dq_oe}, 8'h0);
      rst_n = 1;
      @(negedge clk);

      // R4 R5 normal write/read sweep over every nibble
      for (int a = 0; a < 32; a++) begin
         logic [3:0] v;
         v = 4'((a * 5 + 3) & 15);
         cyc(3'd2, 5'(a), v, 1'b0);
         if (a[0]) model[a >> 1][7:4] = v; else model[a >> 1][3:0] = v;
      end
      for (int a = 0; a < 32; a++) nread(5'(a), "R4 R5 normal readback");

      // R8 read without oe, and bus quiet on a write cycle
      cyc(3'd1, 5'd3, 4'h0, 1'b0);
      chk("R8 no oe", {3'b0, dq_oe, dq_out}, 8'h00);
      cyc(3'd2, 5'd3, model[1][7:4], 1'b1);
      chk("R8 write with oe", {3'b0, dq_oe, dq_out}, 8'h00);

      // R3 refresh in normal mode keeps it off
      for (int k = 4; k < 7; k++) begin
         cyc(3'(k), 5'd0, 4'h0, 1'b0);
         chk("R3 refresh in normal", {7'b0, test_active}, 8'h0);
      end

      // R2 entry and hold
      cyc(3'd3, 5'd0, 4'h0, 1'b0);
      chk("R2 entry", {7'b0, test_active}, 8'h1);
      cyc(3'd3, 5'd0, 4'h0, 1'b0);
      chk("R2 repeat entry", {7'b0, test_active}, 8'h1);
      cyc(3'd7, 5'd0, 4'h0, 1'b0);
      chk("R2 reserved holds", {7'b0, test_active}, 8'h1);

      // R6 R7 R10 test write of every row, upper din bits and addr[0] contrary
      for (int r = 0; r < 16; r++) begin
         logic b;
         b = r[0] ^ r[2];
         cyc(3'd2, 5'({r[3:0], ~r[1]}), {~{3{b}}, b}, 1'b0);
         model[r] = {8{b}};
      end
      for (int r = 0; r < 16; r++) begin
         tread(5'({r[3:0], 1'b0}), "R7 R6 test read sel0");
         tread(5'({r[3:0], 1'b1}), "R10 test read sel1");
      end
      chk("R2 held through rw", {7'b0, test_active}, 8'h1);
      cyc(3'd6, 5'd0, 4'h0, 1'b0);
      chk("R3 hidden refresh exit", {7'b0, test_active}, 8'h0);
      for (int a = 0; a < 32; a++) nread(5'(a), "R6 broadcast contents");

      // R7 compare over every byte value, exits rotate across refresh kinds
      for (int v = 0; v < 256; v++) begin
         cyc(3'd2, 5'd10, 4'(v), 1'b0);
         cyc(3'd2, 5'd11, 4'(v >> 4), 1'b0);
         model[5] = 8'(v);
         cyc(3'd3, 5'd0, 4'h0, 1'b0);
         tread(5'd10, "R7 compare sel0");
         tread(5'd11, "R10 compare sel1");
         cyc(3'(4 + (v % 3)), 5'd0, 4'h0, 1'b0);
         chk("R3 exit", {7'b0, test_active}, 8'h0);
      end

      // R9 non-access cycles leave data intact
      for (int k = 3; k < 8; k++) cyc(3'(k), 5'(k * 3), 4'hF, 1'b1);
      cyc(3'd0, 5'd7, 4'hA, 1'b1);
      chk("R9 mode after sequence", {7'b0, test_active}, 8'h0);
      for (int a = 0; a < 32; a++) nread(5'(a), "R9 data intact");

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule